// File: doc/BRIEF.md
# Interrupt Translation Command Queue Processor

This block walks a ring of 32-byte commands that software places in memory. Software sets the ring base, the ring size in entries and a set of limits, then raises the enable input and writes a new write offset. The block fetches each command one 64-bit doubleword at a time over a simple read port and decodes the command byte. A device-mapping command or a collection-mapping command is turned into one entry-update request to an external table updater. Every other command byte retires without any action.

After each retired command the read offset steps forward, wrapping at the ring size, until it meets the write offset. A failed memory read or a failed table update freezes the ring and raises a sticky stall flag. The stall is cleared only by dropping the enable input and raising it again, which also resets the read offset to zero. Map commands whose fields are out of range are dropped silently, and the walk carries on.

Top module: `cmdq_engine`

## Requirements
- R1: A write-offset write starts a walk only if all of the following hold: the enable input was high in this cycle and the previous one, the block is idle and not stalled, and the new offset differs from the read offset. While `cfg_en` is low, a write-offset write starts nothing.
- R2: Doubleword k of the entry at read offset n is read from `q_base + 32*n + 8*k`. The request is held with a stable address until `mem_rd_ack`.
- R3: The command byte is bits [7:0] of doubleword 0. Only 0x08 (device map) and 0x09 (collection map) do work. Any other byte, 0x05 included, retires after the single doubleword-0 read and raises no update request.
- R4: Device map: the ID comes from doubleword 0 bits [63:32] and the size from doubleword 1 bits [4:0]. The table address comes from doubleword 2 bits [51:8], and the set flag from doubleword 2 bit 63. The block sends `upd_table`=0 with these fields, `upd_target`=0, and holds the request until `upd_done`.
- R5: Collection map: doubleword 1 is not read. From doubleword 2, the ID is bits [15:0], the target is bits [31:16] and the set flag is bit 63. The block sends `upd_table`=1 with `upd_size`=0 and `upd_addr`=0.
- R6: A device map is dropped with no update if its ID is above `max_devid` or its size is above `max_idbits`. A collection map is dropped if its ID is above `max_collid` or its target is above `num_cpu`. In both cases the read offset still advances.
- R7: After each retired command the read offset becomes (offset+1) modulo `q_entries`. The walk stops when the offset equals the write offset. A write landing in the same cycle as the step is honoured.
- R8: A read returned with `mem_rd_err`, or an update answered with `upd_err`, sets `stalled`. The read offset is left on the failing entry, and no further reads are issued.
- R9: A write offset above `q_entries` starts nothing and issues no memory read.
- R10: A rising edge of `cfg_en` clears `stalled` and sets the read offset to 0.
- R11: `busy` is low only when the block is idle. It stays high while stalled with the enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Unit enable |
| q_base | input | AW | Ring base byte address |
| q_entries | input | OW | Ring size in entries |
| max_devid | input | 32 | Highest legal device ID |
| max_idbits | input | 5 | Highest legal device-map size |
| max_collid | input | 16 | Highest legal collection ID |
| num_cpu | input | 16 | Highest legal target number |
| wptr_we | input | 1 | Write-offset write strobe |
| wptr_val | input | OW | Write-offset value |
| mem_rd_req | output | 1 | Doubleword read request |
| mem_addr | output | AW | Read byte address |
| mem_rd_ack | input | 1 | Read response strobe |
| mem_rd_data | input | 64 | Read data |
| mem_rd_err | input | 1 | Read failed |
| upd_valid | output | 1 | Entry-update request |
| upd_table | output | 1 | 0 device table, 1 collection table |
| upd_id | output | 32 | Entry index |
| upd_set | output | 1 | Mapping valid flag |
| upd_size | output | 5 | Device-map size |
| upd_addr | output | 44 | Device-map table address |
| upd_target | output | 16 | Collection target |
| upd_done | input | 1 | Update finished |
| upd_err | input | 1 | Update failed |
| rptr | output | OW | Read offset |
| stalled | output | 1 | Sticky stall flag |
| busy | output | 1 | Not idle |

## Verification
A write-offset write can land in the same cycle as the read offset steps. If the block compared only against the stored offset, it would wrongly go idle. The bench provokes this by writing offset 1 and then offset 3 after a delay swept from 0 to 10 cycles, so one delay lands on the step cycle. In every case it requires exactly three collection updates in order and a final read offset of 3.

// File: rtl/cmdq_engine.sv
module cmdq_engine #(
  parameter int AW = 48,
  parameter int OW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic [AW-1:0] q_base,
  input  logic [OW-1:0] q_entries,
  input  logic [31:0]   max_devid,
  input  logic [4:0]    max_idbits,
  input  logic [15:0]   max_collid,
  input  logic [15:0]   num_cpu,
  input  logic          wptr_we,
  input  logic [OW-1:0] wptr_val,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rd_ack,
  input  logic [63:0]   mem_rd_data,
  input  logic          mem_rd_err,
  output logic          upd_valid,
  output logic          upd_table,
  output logic [31:0]   upd_id,
  output logic          upd_set,
  output logic [4:0]    upd_size,
  output logic [43:0]   upd_addr,
  output logic [15:0]   upd_target,
  input  logic          upd_done,
  input  logic          upd_err,
  output logic [OW-1:0] rptr,
  output logic          stalled,
  output logic          busy
);
  localparam logic [7:0] OP_DEV = 8'h08;
  localparam logic [7:0] OP_COL = 8'h09;

  typedef enum logic [2:0] {S_IDLE, S_F0, S_DEC, S_F1, S_F2, S_UPD, S_ADV, S_STALL} st_t;

  st_t           st;
  logic          en_q;
  logic [OW-1:0] rd_off, wr_off, wr_eff, rd_next;
  logic [OW:0]   rd_inc;
  logic [7:0]    op;
  logic [31:0]   dev_id;
  logic [4:0]    size_q;
  logic [1:0]    dw_sel;
  logic          en_rise, start, is_dev, dev_ok, col_ok, rd_bad, unused_bits;

  assign en_rise = cfg_en & ~en_q;
  assign wr_eff  = wptr_we ? wptr_val : wr_off;
  assign rd_inc  = {1'b0, rd_off} + 1'b1;
  assign rd_next = (rd_inc >= {1'b0, q_entries}) ? '0 : rd_inc[OW-1:0];
  assign start   = wptr_we && cfg_en && en_q && !stalled && (st == S_IDLE) &&
                   (wptr_val != rd_off) && (wptr_val <= q_entries) && (rd_off <= q_entries);

  assign dw_sel     = (st == S_F1) ? 2'd1 : (st == S_F2) ? 2'd2 : 2'd0;
  assign mem_rd_req = (st == S_F0) || (st == S_F1) || (st == S_F2);
  assign mem_addr   = q_base + AW'({rd_off, dw_sel, 3'b000});
  assign rd_bad     = mem_rd_ack && mem_rd_err;

  assign is_dev = (op == OP_DEV);
  assign dev_ok = (dev_id <= max_devid) && (size_q <= max_idbits);
  assign col_ok = (mem_rd_data[15:0] <= max_collid) && (mem_rd_data[31:16] <= num_cpu);
  assign unused_bits = ^mem_rd_data[62:52];

  assign rptr = rd_off;
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; en_q <= 1'b0; rd_off <= '0; wr_off <= '0; stalled <= 1'b0;
      op <= '0; dev_id <= '0; size_q <= '0;
      upd_valid <= 1'b0; upd_table <= 1'b0; upd_id <= '0; upd_set <= 1'b0;
      upd_size <= '0; upd_addr <= '0; upd_target <= '0;
    end else begin
      en_q <= cfg_en;
      if (wptr_we) wr_off <= wptr_val;
      if (en_rise) begin
        st <= S_IDLE; rd_off <= '0; stalled <= 1'b0; upd_valid <= 1'b0;
      end else if (!cfg_en) begin
        st <= S_IDLE; upd_valid <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start) st <= S_F0;
          S_F0: if (rd_bad) begin
                  st <= S_STALL; stalled <= 1'b1;
                end else if (mem_rd_ack) begin
                  op <= mem_rd_data[7:0]; dev_id <= mem_rd_data[63:32]; st <= S_DEC;
                end
          S_DEC: st <= (op == OP_DEV) ? S_F1 : (op == OP_COL) ? S_F2 : S_ADV;
          S_F1: if (rd_bad) begin
                  st <= S_STALL; stalled <= 1'b1;
                end else if (mem_rd_ack) begin
                  size_q <= mem_rd_data[4:0]; st <= S_F2;
                end
          S_F2: if (rd_bad) begin
                  st <= S_STALL; stalled <= 1'b1;
                end else if (mem_rd_ack) begin
                  if (is_dev ? dev_ok : col_ok) begin
                    upd_valid  <= 1'b1;
                    upd_table  <= !is_dev;
                    upd_id     <= is_dev ? dev_id : {16'h0, mem_rd_data[15:0]};
                    upd_set    <= mem_rd_data[63];
                    upd_size   <= is_dev ? size_q : 5'd0;
                    upd_addr   <= is_dev ? mem_rd_data[51:8] : 44'd0;
                    upd_target <= is_dev ? 16'd0 : mem_rd_data[31:16];
                    st <= S_UPD;
                  end else begin
                    st <= S_ADV;
                  end
                end
          S_UPD: if (upd_done) begin
                   upd_valid <= 1'b0;
                   if (upd_err) begin
                     st <= S_STALL; stalled <= 1'b1;
                   end else begin
                     st <= S_ADV;
                   end
                 end
          S_ADV: begin
                   rd_off <= rd_next;
                   st <= ((rd_next == wr_eff) || (wr_eff > q_entries)) ? S_IDLE : S_F0;
                 end
          S_STALL: st <= S_STALL;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wptr_we)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack && cfg_en) |=> (mem_rd_req && $stable(mem_addr))); // R2
  AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_done && cfg_en) |=> (upd_valid && $stable(upd_id) && $stable(upd_table))); // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rptr) |-> ((rptr == '0) || (rptr == $past(rptr) + 1'b1))); // R7
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stalled) |-> $past((mem_rd_req && mem_rd_ack && mem_rd_err) || (upd_valid && upd_done && upd_err))); // R8
  AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && cfg_en && $past(cfg_en)) |=> ($stable(rptr) && !mem_rd_req)); // R8
endmodule

// File: tb/cmdq_engine_test.sv
module cmdq_engine_test;
  localparam int AW = 48;
  localparam int OW = 15;

  logic clk = 0, rst_n = 0, cfg_en = 0;
  logic [AW-1:0] q_base = 48'h1000;
  logic [OW-1:0] q_entries = 8;
  logic [31:0] max_devid = 100;
  logic [4:0]  max_idbits = 16;
  logic [15:0] max_collid = 31, num_cpu = 4;
  logic wptr_we = 0;
  logic [OW-1:0] wptr_val = 0;
  logic mem_rd_req, mem_rd_ack = 0, mem_rd_err = 0;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_rd_data = 0;
  logic upd_valid, upd_table, upd_set, upd_done = 0, upd_err = 0;
  logic [31:0] upd_id;
  logic [4:0] upd_size;
  logic [43:0] upd_addr;
  logic [15:0] upd_target;
  logic [OW-1:0] rptr;
  logic stalled, busy;

  int checks = 0, fails = 0, acks = 0, err_idx = 999;
  bit upd_fail = 0;
  logic [63:0] mem [32];
  logic [98:0] expq [$];

  always #10 clk = ~clk;

  cmdq_engine #(.AW(AW), .OW(OW)) uut (.*);

  function automatic logic [98:0] pk(logic t, logic [31:0] id, logic s, logic [4:0] sz, logic [43:0] a, logic [15:0] tg);
    return {t, id, s, sz, a, tg};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    mem_rd_ack <= mem_rd_req && !mem_rd_ack;
    if (mem_rd_req && !mem_rd_ack) begin
      automatic int idx = int'((mem_addr - q_base) >> 3);
      acks <= acks + 1;
      if (mem_addr[2:0] != 0 || idx < 0 || idx > 31) begin
        mem_rd_data <= 0;
        mem_rd_err <= 1;
      end else begin
        mem_rd_data <= mem[idx];
        mem_rd_err <= (idx == err_idx);
      end
    end
    upd_done <= upd_valid && !upd_done;
    upd_err  <= upd_valid && !upd_done && upd_fail;
  end

  always @(negedge clk) begin
    if (upd_valid && upd_done) begin
      if (expq.size() == 0) check("R6 unexpected update", {29'h0, pk(upd_table, upd_id, upd_set, upd_size, upd_addr, upd_target)}, 128'h0);
      else check("R4/R5 update fields", {29'h0, pk(upd_table, upd_id, upd_set, upd_size, upd_addr, upd_target)}, {29'h0, expq.pop_front()});
    end
  end

  task automatic put_dev(int slot, logic [31:0] dev, logic [4:0] sz, logic [43:0] a, logic v);
    mem[slot*4]   = {dev, 24'h0, 8'h08};
    mem[slot*4+1] = {59'h0, sz};
    mem[slot*4+2] = {v, 11'h0, a, 8'h00};
    mem[slot*4+3] = 64'h0;
  endtask

  task automatic put_col(int slot, logic [15:0] id, logic [15:0] tg, logic v);
    mem[slot*4]   = {56'h0, 8'h09};
    mem[slot*4+1] = 64'hFFFF_FFFF_FFFF_FFFF;
    mem[slot*4+2] = {v, 31'h0, tg, id};
    mem[slot*4+3] = 64'h0;
  endtask

  task automatic put_op(int slot, logic [7:0] op);
    mem[slot*4] = {56'h0, op};
    for (int k = 1; k < 4; k++) mem[slot*4+k] = 64'h0;
  endtask

  task automatic wr_ptr(logic [OW-1:0] v);
    @(negedge clk); wptr_we = 1; wptr_val = v;
    @(negedge clk); wptr_we = 0;
  endtask

  task automatic wait_done();
    repeat (2) @(negedge clk);
    while (busy && !stalled) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic reenable();
    @(negedge clk); cfg_en = 0;
    @(negedge clk); cfg_en = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int a0;
    for (int i = 0; i < 32; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 reset busy", busy, 0);
    check("R10 reset rptr", rptr, 0);
    check("R8 reset stalled", stalled, 0);

    cfg_en = 1; repeat (2) @(negedge clk);
    put_dev(0, 5, 3, 44'hABCDE, 1);
    put_op(1, 8'h05);
    put_col(2, 7, 2, 1);
    put_op(3, 8'h03);
    expq.push_back(pk(0, 5, 1, 3, 44'hABCDE, 0));
    expq.push_back(pk(1, 7, 1, 0, 0, 2));
    wr_ptr(4);
    check("R11 busy while walking", busy, 1);
    wait_done();
    check("R7 rptr after four", rptr, 4);
    check("R3 queue drained", expq.size(), 0);

    put_dev(4, 200, 3, 1, 1);
    put_dev(5, 6, 20, 1, 1);
    put_col(6, 3, 5, 1);
    put_col(7, 9, 4, 0);
    expq.push_back(pk(1, 9, 0, 0, 0, 4));
    wr_ptr(0);
    wait_done();
    check("R7 rptr wrapped", rptr, 0);
    check("R6 only legal update", expq.size(), 0);

    a0 = acks;
    wr_ptr(9);
    check("R9 no start", busy, 0);
    repeat (3) @(negedge clk);
    check("R9 no reads", acks - a0, 0);

    cfg_en = 0; @(negedge clk);
    wr_ptr(2);
    repeat (3) @(negedge clk);
    check("R1 disabled no start", busy, 0);
    check("R1 disabled no reads", acks - a0, 0);
    cfg_en = 1; repeat (2) @(negedge clk);

    put_op(0, 8'h05);
    put_dev(1, 1, 1, 1, 1);
    err_idx = 5;
    a0 = acks;
    wr_ptr(3);
    wait_done();
    check("R8 stalled", stalled, 1);
    check("R8 rptr held", rptr, 1);
    check("R3 reads before stall", acks - a0, 3);
    check("R11 busy when stalled", busy, 1);
    a0 = acks;
    wr_ptr(4);
    repeat (5) @(negedge clk);
    check("R8 no reads while stalled", acks - a0, 0);

    err_idx = 999;
    reenable();
    check("R10 stall cleared", stalled, 0);
    check("R10 rptr zero", rptr, 0);
    put_col(0, 3, 1, 1);
    upd_fail = 1;
    expq.push_back(pk(1, 3, 1, 0, 0, 1));
    wr_ptr(1);
    wait_done();
    check("R8 update error stalls", stalled, 1);
    check("R8 rptr held on update error", rptr, 0);
    upd_fail = 0;

    put_col(0, 10, 0, 1);
    put_col(1, 11, 1, 1);
    put_col(2, 12, 2, 0);
    for (int d = 0; d <= 10; d++) begin
      reenable();
      expq.push_back(pk(1, 10, 1, 0, 0, 0));
      expq.push_back(pk(1, 11, 1, 0, 0, 1));
      expq.push_back(pk(1, 12, 0, 0, 0, 2));
      wr_ptr(1);
      repeat (d) @(negedge clk);
      wr_ptr(3);
      wait_done();
      check("R7 late write honoured", rptr, 3);
      check("R7 all updates seen", expq.size(), 0);
    end

    summary();
  end
endmodule